// File: doc/BRIEF.md
# Synthesizer PLL Divider and Phase-Frequency Detector

This block is the digital front end of a frequency-synthesizer loop. The oscillator clock runs the whole block. A programmable down-counter divides that clock by a ratio N and emits a one-cycle feedback tick once per N cycles. At the default ratios of 9500 to 10000 and a 1 kHz reference, the oscillator settles between 9.5 and 10 MHz in 1 kHz steps.

A sequential phase-frequency detector compares the rising edges of the asynchronous reference against the feedback ticks. It drives separate pump-up and pump-down outputs for an external analog loop filter. Once both edges of a comparison have been seen, both outputs stay high together for a programmable number of cycles before the detector clears. Every reference edge therefore produces a correction, and the detector has no dead band near zero phase error.

A lock flag reports a run of comparisons whose pulses stayed close to the minimum width.

Top module: `synth_pfd`

## Requirements
- R1: `fb_tick` is high for exactly one cycle every N cycles, where N is the active divide ratio.
- R2: A ratio accepted on `div_load` does not shorten or stretch the period in progress. It governs the periods that begin after the next feedback tick.
- R3: A value on `div_value` below N_MIN or above N_MAX is ignored, and the divide period is unchanged.
- R4: The reference rising edge is seen through a two-stage synchronizer. Its detector flag is high from the third cycle after the first cycle in which `ref_in` is high. With `swap_pol` low, a reference that leads the feedback by d cycles holds `pump_dn` high for OVERLAP+d cycles and `pump_up` high for OVERLAP cycles.
- R5: With `swap_pol` low, a reference that lags the feedback by d cycles holds `pump_up` high for OVERLAP+d cycles and `pump_dn` high for OVERLAP cycles.
- R6: With `swap_pol` high, the roles of `pump_up` and `pump_dn` in R4 and R5 are exchanged.
- R7: When the reference and feedback edges land in the same cycle, both pump outputs are high together for exactly OVERLAP cycles, so no comparison passes without a pulse.
- R8: `locked` rises at the end of the LOCK_RUN-th consecutive comparison whose longer pulse lasts no more than OVERLAP+LOCK_SLACK cycles. It falls at the end of the first comparison that exceeds that width.
- R9: While `rst` is high at a clock edge, both pump outputs and `locked` are low in the following cycle, and the divide ratio returns to N_MIN.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock, divided and used for all state |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Asynchronous reference clock |
| div_load | input | 1 | Strobe to accept `div_value` as the next divide ratio |
| div_value | input | DIV_W | Requested divide ratio |
| swap_pol | input | 1 | Exchanges the two pump outputs |
| pump_up | output | 1 | Pump-up request to the loop filter |
| pump_dn | output | 1 | Pump-down request to the loop filter |
| fb_tick | output | 1 | One-cycle divided feedback pulse |
| locked | output | 1 | Lock indication |

## Verification
The bench builds the block with N_MIN=8, N_MAX=40 and DIV_W=6. It keeps OVERLAP=2, LOCK_RUN=8 and LOCK_SLACK=2 at their defaults. With a working ratio of 20, each comparison spans 20 cycles. Reference edges can then be placed anywhere within five cycles either side of a feedback tick, so lead, lag, exact alignment, polarity swap, lock gain and lock loss are all exercised in a few hundred cycles. The smaller ratios also make the boundary loads of 5 and 50 cheap to reject and observe, and they bring the reset ratio, deferred ratio changes and reset in mid-pulse within a short run.

// File: rtl/synth_pfd.sv
`timescale 1ns/1ps
module synth_pfd #(
  parameter int N_MIN      = 9500,
  parameter int N_MAX      = 10000,
  parameter int DIV_W      = 14,
  parameter int OVERLAP    = 2,
  parameter int LOCK_RUN   = 8,
  parameter int LOCK_SLACK = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_in,
  input  logic             div_load,
  input  logic [DIV_W-1:0] div_value,
  input  logic             swap_pol,
  output logic             pump_up,
  output logic             pump_dn,
  output logic             fb_tick,
  output logic             locked
);
  localparam int OV_W = $clog2(OVERLAP + 1);
  localparam int WC_W = $clog2(OVERLAP + LOCK_SLACK + 2) + 1;
  localparam int LK_W = $clog2(LOCK_RUN + 1);
  localparam logic [DIV_W-1:0] N_LO    = DIV_W'(N_MIN);
  localparam logic [DIV_W-1:0] N_HI    = DIV_W'(N_MAX);
  localparam logic [OV_W-1:0]  OV_LAST = OV_W'(OVERLAP - 1);
  localparam logic [WC_W-1:0]  WC_MAX  = '1;
  localparam logic [WC_W-1:0]  GOOD_LIM = WC_W'(OVERLAP + LOCK_SLACK);
  localparam logic [LK_W-1:0]  RUN_MAX = LK_W'(LOCK_RUN);

  logic [2:0]       ref_s;
  logic [DIV_W-1:0] cnt, n_pend;
  logic             ref_flag, fb_flag;
  logic [OV_W-1:0]  ovl;
  logic [WC_W-1:0]  wcnt;
  logic [LK_W-1:0]  good;

  wire ref_rise = ref_s[1] & ~ref_s[2];
  wire in_range = (div_value >= N_LO) && (div_value <= N_HI);
  wire both     = ref_flag & fb_flag;
  wire clr      = both && (ovl == OV_LAST);

  assign fb_tick = (cnt == '0);
  assign pump_dn = swap_pol ? fb_flag : ref_flag;
  assign pump_up = swap_pol ? ref_flag : fb_flag;
  assign locked  = (good == RUN_MAX);

  always_ff @(posedge clk) begin
    if (rst) ref_s <= '0;
    else     ref_s <= {ref_s[1:0], ref_in};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      n_pend <= N_LO;
      cnt    <= N_LO - 1'b1;
    end else begin
      if (div_load && in_range) n_pend <= div_value;
      cnt <= fb_tick ? n_pend - 1'b1 : cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_flag <= 1'b0;
      fb_flag  <= 1'b0;
      ovl      <= '0;
      wcnt     <= '0;
      good     <= '0;
    end else begin
      ref_flag <= (ref_flag & ~clr) | ref_rise;
      fb_flag  <= (fb_flag & ~clr) | fb_tick;
      ovl      <= (both && !clr) ? ovl + 1'b1 : '0;
      if (clr)                                  wcnt <= '0;
      else if ((ref_flag | fb_flag) && wcnt != WC_MAX) wcnt <= wcnt + 1'b1;
      if (clr) begin
        if (wcnt < GOOD_LIM) good <= locked ? good : good + 1'b1;
        else                 good <= '0;
      end
    end
  end

  // R1
  tick_single_chk: assert property (@(posedge clk) disable iff (rst)
    fb_tick |=> !fb_tick);

  // R9
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!pump_up && !pump_dn && !locked));

  // R8
  lock_on_compare_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(clr));

  // R4
  ref_edge_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ref_flag) |-> $past(ref_s[1]));

  generate
    if (OVERLAP > 1) begin : g_ovl_chk
      // R7
      overlap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pump_up && pump_dn) |=> (pump_up && pump_dn));
    end
  endgenerate
endmodule

// File: tb/synth_pfd_tb.sv
`timescale 1ns/1ps
module synth_pfd_tb;
  localparam int DIV_W = 6;
  localparam int OVL   = 2;
  localparam int NW    = 20;
  localparam int NT    = 16;
  localparam int D_TAB [NT] = '{0, 1, -1, 2, -2, 0, 1, -2, 3, 0, -4, 2, -3, 0, 5, -5};
  localparam bit S_TAB [NT] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 1, 0, 0};

  logic clk = 0, rst = 1, ref_in = 0, div_load = 0, swap_pol = 0;
  logic [DIV_W-1:0] div_value = '0;
  logic pump_up, pump_dn, fb_tick, locked;
  int cyc = 0, n_chk = 0, n_bad = 0;

  synth_pfd #(.N_MIN(8), .N_MAX(40), .DIV_W(DIV_W), .OVERLAP(OVL),
              .LOCK_RUN(8), .LOCK_SLACK(2)) u_dut (
    .clk(clk), .rst(rst), .ref_in(ref_in), .div_load(div_load),
    .div_value(div_value), .swap_pol(swap_pol), .pump_up(pump_up),
    .pump_dn(pump_dn), .fb_tick(fb_tick), .locked(locked));

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) if (cyc > 150000) begin
    n_chk++; n_bad++;
    $display("FAIL watchdog: act %0d cycles exp completion", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: act %0d exp %0d", req, act, exp);
    end
  endtask

  task automatic goto(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic wait_tick(output int t);
    do @(negedge clk); while (!fb_tick);
    t = cyc;
  endtask

  initial begin
    int t1, t2, t3, t4, tl, run;
    run = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R9 reset state
    chk(!pump_up && !pump_dn, "R9 pumps", {pump_up, pump_dn}, 0);
    chk(!locked, "R9 locked", locked, 0);
    wait_tick(t1); wait_tick(t2);
    chk(t2 - t1 == 8, "R9 reset ratio", t2 - t1, 8);
    @(negedge clk); chk(!fb_tick, "R1 single cycle", fb_tick, 0);
    goto(t2 + 3); div_load = 1; div_value = NW;
    @(negedge clk); div_load = 0;
    wait_tick(t3); chk(t3 - t2 == 8, "R2 deferred", t3 - t2, 8);
    wait_tick(t4); chk(t4 - t3 == NW, "R2 new ratio", t4 - t3, NW);
    goto(t4 + 2); div_load = 1; div_value = 50;
    @(negedge clk); div_value = 5;
    @(negedge clk); div_load = 0;
    wait_tick(t1); chk(t1 - t4 == NW, "R3 high ignored", t1 - t4, NW);
    wait_tick(t2); chk(t2 - t1 == NW, "R3 low ignored", t2 - t1, NW);
    // warm-up comparison, deliberately wide
    tl = t2;
    goto(tl + 5); ref_in = 1;
    goto(tl + 9); ref_in = 0;
    for (int i = 0; i < NT; i++) begin
      int d, c1, k, nu, nd, eu, ed, lead, lag;
      d = D_TAB[i]; c1 = tl + NW; k = c1 - 2 - d; nu = 0; nd = 0;
      lead = d > 0 ? d : 0; lag = d < 0 ? -d : 0;
      for (int c = c1 - 9; c <= c1 + 9; c++) begin
        goto(c);
        if (c == c1 - 9) swap_pol = S_TAB[i];
        if (c == k) ref_in = 1;
        if (c == k + 4) ref_in = 0;
        if (c == c1) chk(fb_tick == 1, "R1 period", fb_tick, 1);
        nu += pump_up; nd += pump_dn;
      end
      ed = S_TAB[i] ? OVL + lag : OVL + lead;
      eu = S_TAB[i] ? OVL + lead : OVL + lag;
      if (S_TAB[i])      begin chk(nd == ed, "R6 dn", nd, ed); chk(nu == eu, "R6 up", nu, eu); end
      else if (d > 0)    begin chk(nd == ed, "R4 dn", nd, ed); chk(nu == eu, "R4 up", nu, eu); end
      else if (d < 0)    begin chk(nu == eu, "R5 up", nu, eu); chk(nd == ed, "R5 dn", nd, ed); end
      else               begin chk(nu == OVL && nd == OVL, "R7 overlap", nu * 10 + nd, OVL * 11); end
      run = (lead + lag <= 2) ? (run < 8 ? run + 1 : 8) : 0;
      chk(locked == (run >= 8), "R8 lock", locked, run >= 8);
      tl = c1;
    end
    swap_pol = 0;
    begin
      int c1;
      c1 = tl + NW;
      goto(c1 - 7); ref_in = 1;
      goto(c1 - 2);
      chk(pump_dn == 1, "R4 pre-reset dn", pump_dn, 1);
      rst = 1; ref_in = 0;
      @(negedge clk);
      chk(!pump_up && !pump_dn && !locked, "R9 mid-pulse", {pump_up, pump_dn, locked}, 0);
      @(negedge clk); rst = 0;
      wait_tick(t1); wait_tick(t2);
      chk(t2 - t1 == 8, "R9 ratio restored", t2 - t1, 8);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule